// File: doc/BRIEF.md
# Two-Port Register File with Write-Through

This block is a tiny storage array of four words, four bits each, with one write port and one read port that work at the same time on separate addresses. Writes are committed on the rising clock edge whenever the active-low write strobe is asserted. While a write is in progress, a read of the same location returns the live write data instead of the stored word, so the port behaves as if the location were transparent.

The read side has an active-low output enable that gates a tri-state bus. A plain, always-driven copy of the selected word and an enable flag are also brought out, so logic inside the chip can use the read value without resolving high impedance. Address selection on the read side never depends on either enable.

Top module: `regfile_wt`

## Requirements
- R1: The array holds four words of four bits (parameters `DEPTH`, `WIDTH`), each port selecting a word through its own 2-bit address, and every word keeps a value independent of the others.
- R2: A synchronous active-high `rst` clears every word to zero at the rising edge, and it wins over a write strobe asserted in the same cycle.
- R3: When `wr_en_n` is 0 at a rising edge (and `rst` is 0), the word at `wr_addr` takes the value of `wr_data`.
- R4: When `wr_en_n` is 1 at a rising edge, no word changes, whatever `wr_addr` and `wr_data` carry.
- R5: `rd_data` shows the stored word at `rd_addr` within the same cycle, and a write to one address does not disturb a read of a different address in that cycle.
- R6: While `wr_en_n` is 0, `rst` is 0 and `rd_addr` equals `wr_addr`, `rd_data` equals the current `wr_data` and follows every change of it before the edge.
- R7: While `rd_en_n` is 0, `rd_oe` is 1 and `q` carries `rd_data` uninverted, including while `rst` is 1.
- R8: While `rd_en_n` is 1, `rd_oe` is 0 and `q` is high impedance, yet `rd_data` still follows `rd_addr` and the bypass.
- R9: Across back-to-back strobed cycles, each edge writes to the address present at that edge, so a changed `wr_addr` writes a second location and leaves the first intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_en_n | input | 1 | Write strobe, active low |
| wr_addr | input | 2 | Write word select |
| wr_data | input | 4 | Write data |
| rd_en_n | input | 1 | Output enable, active low |
| rd_addr | input | 2 | Read word select |
| q | output | 4 | Tri-state read bus |
| rd_data | output | 4 | Always-driven read value |
| rd_oe | output | 1 | 1 when `q` is driven |

## Verification
The bench targets a read of the address under write, where a design lacking the bypass would return the old word and one with a registered bypass would lag the data by a cycle. It reads with the strobe released but the same address and data present, which catches a bypass that ignores the enable or a write that ignores it. It reads with the output disabled to catch selection gated by the enable, and asserts reset alongside a write to catch a write that wins over reset. Two strobed cycles with different addresses catch a design that latches the address only once per strobe.

// File: rtl/rf_pkg.sv
package rf_pkg;
  parameter int RF_DEPTH_DEF = 4;
  parameter int RF_WIDTH_DEF = 4;

  // one-hot decode of a word index
  function automatic logic [RF_DEPTH_DEF-1:0] word_sel(input int unsigned idx);
    logic [RF_DEPTH_DEF-1:0] s;
    s = '0;
    s[idx] = 1'b1;
    return s;
  endfunction
endpackage

// File: rtl/rf_store.sv
module rf_store #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en_n,
  input  logic [AW-1:0]               wr_addr,
  input  logic [WIDTH-1:0]            wr_data,
  output logic [DEPTH-1:0][WIDTH-1:0] words
);
  logic [DEPTH-1:0][WIDTH-1:0] mem;

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (rst)
          mem[g] <= '0;
        else if (!wr_en_n && (wr_addr == AW'(g)))
          mem[g] <= wr_data;
      end
    end
  endgenerate

  assign words = mem;

  // R2
  clr_chk: assert property (@(posedge clk) rst |=> (mem == '0));

  // R3
  wr_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en_n |=> (mem[$past(wr_addr)] == $past(wr_data)));

  // R4
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en_n |=> $stable(mem));
endmodule

// File: rtl/rf_rdpath.sv
module rf_rdpath #(
  parameter int DEPTH = 4,
  parameter int WIDTH = 4,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0][WIDTH-1:0] words,
  input  logic                        rst,
  input  logic                        wr_en_n,
  input  logic [AW-1:0]               wr_addr,
  input  logic [WIDTH-1:0]            wr_data,
  input  logic                        rd_en_n,
  input  logic [AW-1:0]               rd_addr,
  output logic [WIDTH-1:0]            rd_data,
  output logic                        rd_oe
);
  logic wr_live;
  logic hit;

  assign wr_live = !wr_en_n && !rst;
  assign hit     = wr_live && (rd_addr == wr_addr);

  always_comb begin
    if (hit)
      rd_data = wr_data;
    else
      rd_data = words[rd_addr];
  end

  assign rd_oe = !rd_en_n;
endmodule

// File: rtl/regfile_wt.sv
module regfile_wt #(
  parameter int DEPTH = rf_pkg::RF_DEPTH_DEF,
  parameter int WIDTH = rf_pkg::RF_WIDTH_DEF,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en_n,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en_n,
  input  logic [AW-1:0]    rd_addr,
  output wire  [WIDTH-1:0] q,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_oe
);
  logic [DEPTH-1:0][WIDTH-1:0] words;

  rf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en_n (wr_en_n),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .words   (words)
  );

  rf_rdpath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_rdpath (
    .words   (words),
    .rst     (rst),
    .wr_en_n (wr_en_n),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_en_n (rd_en_n),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .rd_oe   (rd_oe)
  );

  assign q = rd_oe ? rd_data : {WIDTH{1'bz}};

  // R5 (read-after-write through the stored path)
  raw_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en_n |=> ((wr_en_n && (rd_addr == $past(wr_addr)))
                  ? (rd_data == $past(wr_data)) : 1'b1));

  // R7
  drive_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en_n |-> (q == rd_data));
endmodule

// File: tb/test_regfile_wt.sv
module test_regfile_wt;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en_n = 1'b1;
  logic [1:0] wr_addr = '0;
  logic [3:0] wr_data = '0;
  logic       rd_en_n = 1'b0;
  logic [1:0] rd_addr = '0;
  wire  [3:0] q;
  logic [3:0] rd_data;
  logic       rd_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  regfile_wt i_regfile_wt (
    .clk(clk), .rst(rst), .wr_en_n(wr_en_n), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en_n(rd_en_n), .rd_addr(rd_addr),
    .q(q), .rd_data(rd_data), .rd_oe(rd_oe)
  );

  typedef struct packed {
    logic       we_n;
    logic [1:0] wa;
    logic [3:0] wd;
    logic       re_n;
    logic [1:0] ra;
    logic [3:0] ed;
    logic       eo;
  } vec_t;

  localparam int NV = 12;
  localparam logic [14:0] TBL [NV] = '{
    {1'b0, 2'd0, 4'hA, 1'b0, 2'd1, 4'h0, 1'b1},
    {1'b0, 2'd1, 4'h5, 1'b0, 2'd0, 4'hA, 1'b1},
    {1'b0, 2'd2, 4'hC, 1'b0, 2'd2, 4'hC, 1'b1},
    {1'b0, 2'd3, 4'h3, 1'b0, 2'd1, 4'h5, 1'b1},
    {1'b1, 2'd0, 4'hF, 1'b0, 2'd0, 4'hA, 1'b1},
    {1'b1, 2'd2, 4'h0, 1'b0, 2'd2, 4'hC, 1'b1},
    {1'b0, 2'd3, 4'h9, 1'b0, 2'd3, 4'h9, 1'b1},
    {1'b1, 2'd3, 4'h0, 1'b0, 2'd3, 4'h9, 1'b1},
    {1'b1, 2'd0, 4'h0, 1'b1, 2'd0, 4'hA, 1'b0},
    {1'b0, 2'd1, 4'hE, 1'b1, 2'd1, 4'hE, 1'b0},
    {1'b1, 2'd0, 4'h0, 1'b0, 2'd1, 4'hE, 1'b1},
    {1'b1, 2'd0, 4'h0, 1'b0, 2'd2, 4'hC, 1'b1}
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(8 * 20000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    vec_t v;
    // reset: R7 enable flag follows rd_en_n during reset
    step(); #1;
    chk("R7 oe during reset", {3'b0, rd_oe}, 4'h1);
    step();
    rst = 1'b0;
    // R2 reset state, R1 all four addresses
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      chk("R2 word zero after reset", rd_data, 4'h0);
    end

    // table walk: R3 R4 R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      step();
      v = vec_t'(TBL[i]);
      wr_en_n = v.we_n; wr_addr = v.wa; wr_data = v.wd;
      rd_en_n = v.re_n; rd_addr = v.ra;
      #1;
      chk($sformatf("R3/R4/R5/R6 rd_data vec %0d", i), rd_data, v.ed);
      chk($sformatf("R7/R8 rd_oe vec %0d", i), {3'b0, rd_oe}, {3'b0, v.eo});
      if (v.eo) chk($sformatf("R7 q vec %0d", i), q, v.ed);
    end

    // R1: all words distinct (A,E,C,9)
    step(); wr_en_n = 1'b1; rd_en_n = 1'b0;
    rd_addr = 2'd0; #1; chk("R1 word0", rd_data, 4'hA);
    rd_addr = 2'd1; #1; chk("R1 word1", rd_data, 4'hE);
    rd_addr = 2'd2; #1; chk("R1 word2", rd_data, 4'hC);
    rd_addr = 2'd3; #1; chk("R1 word3", rd_data, 4'h9);

    // R6: live data follows within one strobed cycle
    step();
    wr_en_n = 1'b0; wr_addr = 2'd2; rd_addr = 2'd2;
    wr_data = 4'h1; #1; chk("R6 follow 1", rd_data, 4'h1);
    wr_data = 4'h6; #1; chk("R6 follow 6", rd_data, 4'h6);
    rd_addr = 2'd0; #1; chk("R5 other addr during write", rd_data, 4'hA);
    step(); wr_en_n = 1'b1; rd_addr = 2'd2; #1;
    chk("R3 last live value committed", rd_data, 4'h6);

    // R8: selection not gated by disabled output
    rd_en_n = 1'b1; rd_addr = 2'd3; #1;
    chk("R8 rd_data follows addr while disabled", rd_data, 4'h9);
    chk("R8 oe low", {3'b0, rd_oe}, 4'h0);
    rd_en_n = 1'b0;

    // R9: consecutive strobed cycles, changed address
    step(); wr_en_n = 1'b0; wr_addr = 2'd0; wr_data = 4'h4;
    step(); wr_addr = 2'd1; wr_data = 4'hB;
    step(); wr_en_n = 1'b1;
    rd_addr = 2'd0; #1; chk("R9 first address written", rd_data, 4'h4);
    rd_addr = 2'd1; #1; chk("R9 second address written", rd_data, 4'hB);

    // R4: strobe high, junk on write port
    wr_addr = 2'd1; wr_data = 4'h0; rd_addr = 2'd1;
    step(); step(); #1;
    chk("R4 no change with strobe high", rd_data, 4'hB);

    // R2: reset wins over a simultaneous write
    step(); rst = 1'b1; wr_en_n = 1'b0; wr_addr = 2'd3; wr_data = 4'h7;
    step(); rst = 1'b0; wr_en_n = 1'b1;
    for (int a = 0; a < 4; a++) begin
      rd_addr = 2'(a); #1;
      chk("R2 cleared despite write", rd_data, 4'h0);
    end

    finish_run();
  end
endmodule